// File: doc/BRIEF.md
# Vector Compare Predicate Mask Generator

This block executes a compare-and-branch operation whose meaning depends on how its two source operands are tagged. When both sources are plain scalars it behaves as an ordinary conditional branch and reports a single taken or not-taken decision. When either source carries a vector tag, no branch decision is made. The block compares the operands element by element over the active vector length. It assembles a predicate bitfield with one bit per element and issues that bitfield as a write to an integer destination register.

An operation is launched with a single-cycle `start` that carries the operand tags, a 2-bit condition code, the vector length and the destination register index. Operand values then arrive from the register read path, one element pair per `elem_valid` beat, and the beats may be spaced with idle cycles. A scalar operand that takes part in a vector operation is taken from the first beat and reused for every element. The result is either a one-cycle branch report or a one-cycle mask write. Computing the branch target and storing into the register file are left to neighbouring logic.

Top module: `vcmp_mask_unit`

## Requirements
- R1: After reset `busy`, `br_valid` and `mask_we` are all low.
- R2: With both tags clear, the block consumes exactly one beat. On the cycle after that beat, `br_valid` is high for one cycle and `br_taken` equals the condition applied to the beat's operands, and no mask write occurs.
- R3: With either tag set, the block consumes one beat per element. Bit i of `mask_data` is set exactly when the condition holds for element i.
- R4: In a vector operation, an operand whose tag is clear takes its value from beat 0 for every element, and the values on that lane in later beats have no effect on the mask.
- R5: Mask bits at positions at or above the effective vector length are written as zero.
- R6: `mask_reg` during the write equals the destination index presented with `start`.
- R7: Condition code 0 tests equality, 1 tests inequality, 2 tests signed less-than and 3 tests unsigned less-than, with src1 on the left.
- R8: `mask_we` is a single-cycle pulse on the cycle after the final element beat, and `busy` is low in that same cycle.
- R9: A vector operation with length zero consumes no beats and writes an all-zero mask on the cycle after `start`.
- R10: `start` while `busy` is high is ignored. `elem_valid` while idle has no effect on any output.
- R11: A requested length above MAX_VL is treated as MAX_VL.
- R12: `br_valid` and `mask_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch an operation (accepted when idle) |
| src1_vec | input | 1 | Source 1 is vector-tagged |
| src2_vec | input | 1 | Source 2 is vector-tagged |
| cond | input | 2 | Compare condition code |
| vl | input | VLW | Requested vector length |
| dest | input | RIDW | Destination integer register for the mask |
| elem_valid | input | 1 | Element pair present this cycle |
| elem_a | input | XLEN | Source 1 element value |
| elem_b | input | XLEN | Source 2 element value |
| busy | output | 1 | Operation in progress, waiting for beats |
| br_valid | output | 1 | Branch decision pulse |
| br_taken | output | 1 | Branch decision, valid with br_valid |
| mask_we | output | 1 | Mask write pulse |
| mask_reg | output | RIDW | Register index for the mask write |
| mask_data | output | XLEN | Predicate bitfield |

## Verification
A wrong element index or a lost beat count shows up in the same written mask. Bits land in the wrong position, or the write pulse comes one beat early or late against a beat count the bench knows exactly. A stale scalar hold register or a wrong condition decode corrupts individual mask bits or the branch decision. These errors appear on the one result cycle that follows the last beat. The bench therefore compares the full mask word, the register index and the pulse timing at that cycle, and again on the cycle after it.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    typedef enum logic [1:0] {
        CC_EQ  = 2'd0,
        CC_NE  = 2'd1,
        CC_LTS = 2'd2,
        CC_LTU = 2'd3
    } cc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

endpackage

// File: rtl/vcmp_cond_eval.sv
module vcmp_cond_eval
    import vcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  cc_e          cc,
    output logic         hit
);
    always_comb begin
        unique case (cc)
            CC_EQ:   hit = (lhs == rhs);
            CC_NE:   hit = (lhs != rhs);
            CC_LTS:  hit = ($signed(lhs) < $signed(rhs));
            default: hit = (lhs < rhs);
        endcase
    end
endmodule

// File: rtl/vcmp_scalar_hold.sv
module vcmp_scalar_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         use_live,
    input  logic [W-1:0] live,
    output logic [W-1:0] eff
);
    logic [W-1:0] held_d;
    logic [W-1:0] held_q;

    always_comb begin
        held_d = held_q;
        if (take) begin
            held_d = live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= held_d;
        end
    end

    assign eff = use_live ? live : held_q;
endmodule

// File: rtl/vcmp_mask_unit.sv
module vcmp_mask_unit
    import vcmp_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int MAX_VL = 16,
    parameter int RIDW   = 5,
    parameter int VLW    = $clog2(MAX_VL) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            src1_vec,
    input  logic            src2_vec,
    input  logic [1:0]      cond,
    input  logic [VLW-1:0]  vl,
    input  logic [RIDW-1:0] dest,
    input  logic            elem_valid,
    input  logic [XLEN-1:0] elem_a,
    input  logic [XLEN-1:0] elem_b,
    output logic            busy,
    output logic            br_valid,
    output logic            br_taken,
    output logic            mask_we,
    output logic [RIDW-1:0] mask_reg,
    output logic [XLEN-1:0] mask_data
);
    localparam logic [VLW-1:0] VL_CAP = VLW'(MAX_VL);
    localparam int NOPS = 2;

    typedef struct packed {
        st_e             st;
        logic [VLW-1:0]  idx;
        logic [VLW-1:0]  len;
        logic [XLEN-1:0] mask;
        logic [RIDW-1:0] dst;
        cc_e             cc;
        logic            v1;
        logic            v2;
        logic            we;
        logic            bv;
        logic            bt;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic            beat;
    logic            first_beat;
    logic            hit;
    logic [VLW-1:0]  vl_eff;
    logic [XLEN-1:0] lane_live [NOPS];
    logic [XLEN-1:0] lane_eff  [NOPS];
    logic            lane_vec  [NOPS];

    assign beat       = (ctl_q.st == ST_RUN) && elem_valid;
    assign first_beat = (ctl_q.idx == '0);
    assign vl_eff     = (vl > VL_CAP) ? VL_CAP : vl;

    assign lane_live[0] = elem_a;
    assign lane_live[1] = elem_b;
    assign lane_vec[0]  = ctl_q.v1;
    assign lane_vec[1]  = ctl_q.v2;

    for (genvar g = 0; g < NOPS; g++) begin : g_lane
        vcmp_scalar_hold #(.W(XLEN)) hold_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (beat && first_beat),
            .use_live (lane_vec[g] || first_beat),
            .live     (lane_live[g]),
            .eff      (lane_eff[g])
        );
    end

    vcmp_cond_eval #(.W(XLEN)) eval_i (
        .lhs (lane_eff[0]),
        .rhs (lane_eff[1]),
        .cc  (ctl_q.cc),
        .hit (hit)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.we = 1'b0;
        ctl_d.bv = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.cc   = cc_e'(cond);
                    ctl_d.v1   = src1_vec;
                    ctl_d.v2   = src2_vec;
                    ctl_d.dst  = dest;
                    ctl_d.idx  = '0;
                    ctl_d.mask = '0;
                    if (!src1_vec && !src2_vec) begin
                        ctl_d.len = VLW'(1);
                        ctl_d.st  = ST_RUN;
                    end else if (vl_eff == '0) begin
                        ctl_d.len = '0;
                        ctl_d.we  = 1'b1;
                    end else begin
                        ctl_d.len = vl_eff;
                        ctl_d.st  = ST_RUN;
                    end
                end
            end
            default: begin
                if (elem_valid) begin
                    if (!ctl_q.v1 && !ctl_q.v2) begin
                        ctl_d.bv = 1'b1;
                        ctl_d.bt = hit;
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.mask = ctl_q.mask | (XLEN'(hit) << ctl_q.idx);
                        ctl_d.idx  = ctl_q.idx + VLW'(1);
                        if (ctl_q.idx + VLW'(1) == ctl_q.len) begin
                            ctl_d.we = 1'b1;
                            ctl_d.st = ST_IDLE;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cc: CC_EQ, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st == ST_RUN);
    assign br_valid  = ctl_q.bv;
    assign br_taken  = ctl_q.bt;
    assign mask_we   = ctl_q.we;
    assign mask_reg  = ctl_q.dst;
    assign mask_data = ctl_q.mask;

    // R8: write strobe lasts one cycle and arrives with busy already low
    a_r8_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> !mask_we);
    a_r8_we_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |-> !busy);
    // R12: the two result kinds never coincide
    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_we && br_valid));
    // R5: no bit survives above the stored length
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |-> ((mask_data >> ctl_q.len) == '0));
    // R2: a branch report always follows a consumed beat
    a_r2_br_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> $past(busy && elem_valid));
    // R10: a start during an operation leaves the destination untouched
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(mask_reg));
    // R9: zero-length vector request writes at once
    a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (src1_vec || src2_vec) && vl == '0)
        |=> (mask_we && !busy && mask_data == '0));
    // R11: the stored length never exceeds the cap
    a_r11_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ctl_q.len <= VL_CAP));
endmodule

// File: tb/vcmp_mask_unit_tb_top.sv
`timescale 1ns/1ps
module vcmp_mask_unit_tb_top;
    localparam int XLEN   = 32;
    localparam int MAX_VL = 16;
    localparam int RIDW   = 5;
    localparam int VLW    = $clog2(MAX_VL) + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            src1_vec = 1'b0;
    logic            src2_vec = 1'b0;
    logic [1:0]      cond = '0;
    logic [VLW-1:0]  vl = '0;
    logic [RIDW-1:0] dest = '0;
    logic            elem_valid = 1'b0;
    logic [XLEN-1:0] elem_a = '0;
    logic [XLEN-1:0] elem_b = '0;
    logic            busy;
    logic            br_valid;
    logic            br_taken;
    logic            mask_we;
    logic [RIDW-1:0] mask_reg;
    logic [XLEN-1:0] mask_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [XLEN-1:0] va [32];
    logic [XLEN-1:0] vb [32];

    always #2 clk = ~clk;

    vcmp_mask_unit #(.XLEN(XLEN), .MAX_VL(MAX_VL), .RIDW(RIDW), .VLW(VLW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .src1_vec(src1_vec), .src2_vec(src2_vec),
        .cond(cond), .vl(vl), .dest(dest), .elem_valid(elem_valid), .elem_a(elem_a),
        .elem_b(elem_b), .busy(busy), .br_valid(br_valid), .br_taken(br_taken),
        .mask_we(mask_we), .mask_reg(mask_reg), .mask_data(mask_data)
    );

    function automatic logic ref_cmp(logic [1:0] c, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
        case (c)
            2'd0:    return a == b;
            2'd1:    return a != b;
            2'd2:    return $signed(a) < $signed(b);
            default: return a < b;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] pick_val();
        case ($urandom_range(0, 5))
            0:       return 32'h0;
            1:       return 32'hFFFF_FFFF;
            2:       return 32'h8000_0000;
            3:       return 32'h7FFF_FFFF;
            4:       return XLEN'($urandom_range(0, 3));
            default: return $urandom();
        endcase
    endfunction

    function automatic int eff_len(logic [VLW-1:0] l);
        return (int'(l) > MAX_VL) ? MAX_VL : int'(l);
    endfunction

    function automatic logic [XLEN-1:0] ref_mask(logic v1, logic v2, logic [1:0] c, int n);
        logic [XLEN-1:0] m = '0;
        for (int i = 0; i < n; i++) begin
            m[i] = ref_cmp(c, v1 ? va[i] : va[0], v2 ? vb[i] : vb[0]);
        end
        return m;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    // One full operation; gap inserts idle cycles, poke issues a start mid-run
    task automatic run_op(logic v1, logic v2, logic [1:0] c, logic [VLW-1:0] l,
                          logic [RIDW-1:0] d, bit gap, bit poke);
        int n;
        logic [XLEN-1:0] em;
        logic el;
        n = (!v1 && !v2) ? 1 : eff_len(l);
        @(negedge clk);
        start = 1; src1_vec = v1; src2_vec = v2; cond = c; vl = l; dest = d;
        @(negedge clk);
        start = 0;
        if (n == 0) begin
            chk("R9 zero-length write", {62'd0, mask_we, busy}, 64'h2);
            chk("R9 zero mask", mask_data, 0);
            chk("R6 dest on zero-length", mask_reg, d);
            @(negedge clk);
            chk("R8 single pulse", mask_we, 0);
            return;
        end
        chk("R2 R3 busy after start", busy, 1);
        for (int k = 0; k < n; k++) begin
            if (gap && $urandom_range(0, 2) == 0) begin
                elem_valid = 0;
                elem_a = $urandom();
                elem_b = $urandom();
                @(negedge clk);
            end
            elem_valid = 1;
            elem_a = va[k];
            elem_b = vb[k];
            if (poke && k == n / 2) begin
                start = 1; dest = ~d; src1_vec = 0; src2_vec = 0; vl = 0;
            end
            @(negedge clk);
            start = 0;
            if (k < n - 1) begin
                chk("R8 no early write", {62'd0, mask_we, br_valid}, 0);
            end
        end
        elem_valid = 0;
        if (!v1 && !v2) begin
            el = ref_cmp(c, va[0], vb[0]);
            chk("R2 branch valid", {62'd0, br_valid, mask_we}, 64'h2);
            chk("R2 R7 branch taken", br_taken, el);
            chk("R12 busy low after branch", busy, 0);
        end else begin
            em = ref_mask(v1, v2, c, n);
            chk("R8 write pulse", {62'd0, mask_we, busy}, 64'h2);
            chk("R3 R4 R5 R7 mask", mask_data, em);
            chk(poke ? "R10 dest kept" : "R6 dest", mask_reg, d);
            chk("R12 no branch with write", br_valid, 0);
        end
        @(negedge clk);
        chk("R8 R2 single pulse", {62'd0, mask_we, br_valid}, 0);
    endtask

    task automatic fill_rand();
        for (int i = 0; i < 32; i++) begin
            va[i] = pick_val();
            vb[i] = pick_val();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {61'd0, busy, br_valid, mask_we}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", {61'd0, busy, br_valid, mask_we}, 0);

        // R10: beats while idle do nothing
        elem_valid = 1; elem_a = 5; elem_b = 5;
        repeat (3) @(negedge clk);
        elem_valid = 0;
        chk("R10 idle beats ignored", {61'd0, busy, br_valid, mask_we}, 0);

        // R7: each condition on a signed/unsigned split
        for (int c = 0; c < 4; c++) begin
            va[0] = 32'h8000_0000; vb[0] = 32'h1;
            run_op(0, 0, 2'(c), 5'd0, 5'd3, 0, 0);
            va[0] = 32'h7; vb[0] = 32'h7;
            run_op(0, 0, 2'(c), 5'd0, 5'd3, 0, 0);
        end

        // R3 R7: vector-vector with known pattern
        for (int i = 0; i < 32; i++) begin
            va[i] = XLEN'(i);
            vb[i] = XLEN'(5);
        end
        run_op(1, 1, 2'd3, 5'd8, 5'd9, 0, 0);
        run_op(1, 1, 2'd0, 5'd8, 5'd9, 0, 0);

        // R4: scalar src1, later lane-a values are junk
        fill_rand();
        run_op(0, 1, 2'd2, 5'd6, 5'd12, 1, 0);
        run_op(1, 0, 2'd1, 5'd6, 5'd13, 1, 0);

        // R11: oversize length clamps; R5 via full-word compare
        fill_rand();
        run_op(1, 1, 2'd1, 5'd31, 5'd1, 0, 0);
        run_op(1, 1, 2'd1, 5'd16, 5'd2, 0, 0);
        run_op(1, 0, 2'd0, 5'd1, 5'd4, 0, 0);

        // R9: zero length
        run_op(1, 1, 2'd0, 5'd0, 5'd21, 0, 0);
        run_op(0, 1, 2'd3, 5'd0, 5'd22, 0, 0);

        // R10: start during an operation
        fill_rand();
        run_op(1, 1, 2'd2, 5'd10, 5'd7, 0, 1);

        // random mix
        for (int t = 0; t < 80; t++) begin
            logic rv1, rv2;
            fill_rand();
            rv1 = 1'($urandom_range(0, 1));
            rv2 = 1'($urandom_range(0, 1));
            run_op(rv1, rv2, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)),
                   5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 7) == 0));
        end
        finish_run();
    end
endmodule